// File: doc/BRIEF.md
# 16-bit ALU with Status Flags

This block is a combinational 16-bit arithmetic and logic unit paired with an 8-bit status register. A 4-bit function code selects one of thirteen operations on a left-hand and a right-hand operand. The result appears on the output in the same cycle. When the function produces flags, the register captures sign, carry, overflow and zero in its upper nibble on the next rising clock edge.

The lower nibble of the status word is a selector field owned by other logic. A flag update never changes it. The carry used by add-with-carry and subtract-with-borrow is the carry bit already held in the status register.

A separate load path copies a full byte from a data bus into the status register. It wins over any flag update in the same cycle. The interface has no back-pressure: both operands and the controls are plain pins, sampled every cycle.

Top module: `alu_status_unit`

## Requirements
- R1: Function codes 2 AND, 3 OR, 4 XOR, 5 NOR, 6 shift-left-by-one, 7 logical shift-right-by-one and 8 NOT-of-left produce that 16-bit result on `result_o` in the same cycle.
- R2: Code 0 gives lhs+rhs and code 1 gives lhs-rhs, both modulo 2^16.
- R3: Code 9 gives lhs+rhs+C and code 10 gives lhs-rhs-C, where C is status bit 6 as it stands before the edge.
- R4: On a flag update, status bit 7 takes result bit 15.
- R5: On a flag update, status bit 6 takes bit 16 of the 17-bit two's-complement result. This bit is the borrow for subtraction, 1 for NOT and NOR, the old bit 15 for shift-left, and 0 for AND/OR/XOR/shift-right.
- R6: On a flag update, status bit 5 is set when lhs bit 15 equals rhs bit 15 and result bit 15 differs from them. The same rule applies for every code.
- R7: On a flag update, status bit 4 is set when the 16-bit result is zero.
- R8: A flag update leaves status bits 3:0 unchanged.
- R9: Codes 11 (no-op), 12 (PC-increment) and the unused codes 13 to 15 drive `result_o` to 0 and leave the status register unchanged. Any code leaves it unchanged while `flag_hold_i` is high.
- R10: While `sw_load_i` is high, the next edge loads all 8 bits from `sw_bus_i`, regardless of any flag update.
- R11: After reset the status word is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lhs_i | input | 16 | Left-hand operand |
| rhs_i | input | 16 | Right-hand operand |
| fn_i | input | 4 | Function code |
| flag_hold_i | input | 1 | Suppresses the flag write this cycle |
| sw_load_i | input | 1 | Loads the status word from the bus |
| sw_bus_i | input | 8 | Status word value to load |
| result_o | output | 16 | ALU result |
| status_o | output | 8 | Status register: sign, carry, overflow, zero, then the 4-bit selector field |

## Verification
The bound checker checks on every cycle:
- that a bus load takes priority;
- that the selector nibble survives when no load occurs;
- that the register holds on suppressed cycles;
- that the sign, zero and overflow bits follow the previous cycle's operands and result.

Only the bench scenarios can show the carry bit and the arithmetic itself. These cover borrow on subtraction, carry chaining through add-with-carry and subtract-with-borrow, and the forced carry of NOT and NOR, all checked against a reference model.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;
  typedef enum logic [3:0] {
    FN_ADD = 4'd0, FN_SUB = 4'd1, FN_AND = 4'd2, FN_OR = 4'd3,
    FN_XOR = 4'd4, FN_NOR = 4'd5, FN_SHL = 4'd6, FN_SHR = 4'd7,
    FN_NOT = 4'd8, FN_ADC = 4'd9, FN_SBB = 4'd10, FN_NOP = 4'd11,
    FN_PCI = 4'd12
  } alu_fn_e;

  localparam int SW_W    = 8;
  localparam int SW_SIGN = 7;
  localparam int SW_CARY = 6;
  localparam int SW_OVFL = 5;
  localparam int SW_ZERO = 4;
  localparam int SEL_W   = 4;

  localparam logic [3:0] FN_LAST_FLAGGED = FN_SBB;
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_status_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  input  logic [3:0]    fn,
  input  logic          cin,
  output logic [DW:0]   wide
);
  localparam int EW = DW + 1;
  logic [EW-1:0] l_e, r_e, c_e;

  assign l_e = {1'b0, lhs};
  assign r_e = {1'b0, rhs};
  assign c_e = {{DW{1'b0}}, cin};

  always_comb begin
    case (fn)
      FN_ADD:  wide = l_e + r_e;
      FN_SUB:  wide = l_e - r_e;
      FN_AND:  wide = l_e & r_e;
      FN_OR:   wide = l_e | r_e;
      FN_XOR:  wide = l_e ^ r_e;
      FN_NOR:  wide = ~(l_e | r_e);
      FN_SHL:  wide = {lhs, 1'b0};
      FN_SHR:  wide = {2'b00, lhs[DW-1:1]};
      FN_NOT:  wide = ~l_e;
      FN_ADC:  wide = l_e + r_e + c_e;
      FN_SBB:  wide = l_e - r_e - c_e;
      default: wide = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_status_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW:0]   wide,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  input  logic [3:0]    fn,
  input  logic          hold,
  output logic [3:0]    flags,
  output logic          upd
);
  localparam int MSB = DW - 1;
  logic sgn, cy, ov, zr;

  assign sgn = wide[MSB];
  assign cy  = wide[DW];
  assign ov  = (lhs[MSB] == rhs[MSB]) && (wide[MSB] != lhs[MSB]);
  assign zr  = (wide[MSB:0] == '0);

  // ordered as status bits 7..4
  assign flags = {sgn, cy, ov, zr};
  assign upd   = !hold && (fn <= FN_LAST_FLAGGED);
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import alu_status_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SW_W-1:0] bus,
  input  logic            upd,
  input  logic [3:0]      flags,
  output logic [SW_W-1:0] sw
);
  always_ff @(posedge clk) begin
    if (!rst_n)      sw <= '0;
    else if (load)   sw <= bus;
    else if (upd)    sw <= {flags, sw[SEL_W-1:0]};
  end
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_status_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] lhs_i,
  input  logic [DW-1:0] rhs_i,
  input  logic [3:0]    fn_i,
  input  logic          flag_hold_i,
  input  logic          sw_load_i,
  input  logic [7:0]    sw_bus_i,
  output logic [DW-1:0] result_o,
  output logic [7:0]    status_o
);
  logic [DW:0] wide;
  logic [3:0]  flags;
  logic        upd;

  alu_core #(.DW(DW)) u_core (
    .lhs(lhs_i), .rhs(rhs_i), .fn(fn_i), .cin(status_o[SW_CARY]), .wide(wide)
  );

  alu_flag_gen #(.DW(DW)) u_flags (
    .wide(wide), .lhs(lhs_i), .rhs(rhs_i), .fn(fn_i), .hold(flag_hold_i),
    .flags(flags), .upd(upd)
  );

  alu_status_reg u_sw (
    .clk(clk), .rst_n(rst_n), .load(sw_load_i), .bus(sw_bus_i),
    .upd(upd), .flags(flags), .sw(status_o)
  );

  assign result_o = wide[DW-1:0];
endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] lhs_i,
  input logic [DW-1:0] rhs_i,
  input logic [3:0]    fn_i,
  input logic          flag_hold_i,
  input logic          sw_load_i,
  input logic [7:0]    sw_bus_i,
  input logic [DW-1:0] result_o,
  input logic [7:0]    status_o
);
  logic writes_flags;
  assign writes_flags = !sw_load_i && !flag_hold_i && (fn_i <= 4'd10);

  // R10
  load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_load_i |=> status_o == $past(sw_bus_i));

  // R8
  sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_load_i |=> status_o[3:0] == $past(status_o[3:0]));

  // R9
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_load_i && (flag_hold_i || fn_i > 4'd10)) |=> $stable(status_o));

  // R9
  idle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i > 4'd10) |-> result_o == '0);

  // R4
  sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    writes_flags |=> status_o[7] == $past(result_o[DW-1]));

  // R7
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    writes_flags |=> status_o[4] == ($past(result_o) == '0));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    writes_flags |=> status_o[5] ==
      ($past(lhs_i[DW-1]) == $past(rhs_i[DW-1]) &&
       $past(result_o[DW-1]) != $past(lhs_i[DW-1])));
endmodule

bind alu_status_unit alu_status_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_alu_status_unit.sv
module sim_alu_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] lhs = '0, rhs = '0;
  logic [3:0]  fn = 4'd11;
  logic        hold = 1'b0, ld = 1'b0;
  logic [7:0]  bus = '0;
  logic [15:0] result;
  logic [7:0]  status;
  logic [7:0]  exp_sw = '0;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  alu_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .lhs_i(lhs), .rhs_i(rhs), .fn_i(fn),
    .flag_hold_i(hold), .sw_load_i(ld), .sw_bus_i(bus),
    .result_o(result), .status_o(status)
  );

  function automatic logic [16:0] ref17(logic [15:0] l, logic [15:0] r,
                                        logic [3:0] f, logic c);
    logic [16:0] a = {1'b0, l}, b = {1'b0, r};
    case (f)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a & b;
      4'd3:  return a | b;
      4'd4:  return a ^ b;
      4'd5:  return ~(a | b);
      4'd6:  return {l, 1'b0};
      4'd7:  return {2'b00, l[15:1]};
      4'd8:  return ~a;
      4'd9:  return a + b + {16'd0, c};
      4'd10: return a - b - {16'd0, c};
      default: return '0;
    endcase
  endfunction

  function automatic string fn_tag(logic [3:0] f);
    if (f <= 4'd1) return "R2";
    if (f <= 4'd8) return "R1";
    if (f <= 4'd10) return "R3";
    return "R9";
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic step(logic [15:0] l, logic [15:0] r, logic [3:0] f,
                      logic h, logic load, logic [7:0] b);
    logic [16:0] w;
    logic [7:0]  nx;
    lhs = l; rhs = r; fn = f; hold = h; ld = load; bus = b;
    #1;
    w = ref17(l, r, f, exp_sw[6]);
    chk(fn_tag(f), result, w[15:0]);
    nx = exp_sw;
    if (load) nx = b;
    else if (!h && f <= 4'd10)
      nx = {w[15], w[16], (l[15] == r[15]) && (w[15] != l[15]),
            w[15:0] == 16'd0, exp_sw[3:0]};
    @(posedge clk); #1;
    exp_sw = nx;
    if (load) chk("R10", {8'd0, status}, {8'd0, nx});
    else if (h || f > 4'd10) chk("R9", {8'd0, status}, {8'd0, nx});
    else begin
      chk("R4", {15'd0, status[7]}, {15'd0, nx[7]});
      chk("R5", {15'd0, status[6]}, {15'd0, nx[6]});
      chk("R6", {15'd0, status[5]}, {15'd0, nx[5]});
      chk("R7", {15'd0, status[4]}, {15'd0, nx[4]});
      chk("R8", {12'd0, status[3:0]}, {12'd0, nx[3:0]});
    end
    @(negedge clk);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R11", {8'd0, status}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: load selector nibble 0x5 with the flags clear, while an add is requested
    step(16'h1234, 16'h0001, 4'd0, 1'b0, 1'b1, 8'h05);
    // R6 R4: positive overflow
    step(16'h7FFF, 16'h0001, 4'd0, 1'b0, 1'b0, 8'h00);
    // R5 R7: carry out with a zero result
    step(16'hFFFF, 16'h0001, 4'd0, 1'b0, 1'b0, 8'h00);
    // R3: add-with-carry consumes the carry
    step(16'h0010, 16'h0020, 4'd9, 1'b0, 1'b0, 8'h00);
    // R5: borrow on subtract
    step(16'h0000, 16'h0001, 4'd1, 1'b0, 1'b0, 8'h00);
    // R3: subtract-with-borrow
    step(16'h0100, 16'h0001, 4'd10, 1'b0, 1'b0, 8'h00);
    // R5: NOT and NOR force the carry high
    step(16'hFFFF, 16'h0000, 4'd8, 1'b0, 1'b0, 8'h00);
    step(16'h0F0F, 16'hF000, 4'd5, 1'b0, 1'b0, 8'h00);
    // R1 R5: shifts
    step(16'h8001, 16'h0000, 4'd6, 1'b0, 1'b0, 8'h00);
    step(16'h8001, 16'h0000, 4'd7, 1'b0, 1'b0, 8'h00);
    // R9: hold, no-op, PC-increment, unused code
    step(16'h0000, 16'h0000, 4'd0, 1'b1, 1'b0, 8'h00);
    step(16'h8000, 16'h8000, 4'd11, 1'b0, 1'b0, 8'h00);
    step(16'h8000, 16'h8000, 4'd12, 1'b0, 1'b0, 8'h00);
    step(16'h8000, 16'h8000, 4'd15, 1'b0, 1'b0, 8'h00);
    // R10: load wins over a flag-producing op
    step(16'h0000, 16'h0000, 4'd0, 1'b0, 1'b1, 8'hAA);
    for (int i = 0; i < 400; i++)
      step(16'($urandom), 16'($urandom), 4'($urandom % 16),
           ($urandom % 8) == 0, ($urandom % 10) == 0, 8'($urandom));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule